// File: doc/BRIEF.md
# Shared-Bus Round-Robin Frame Arbiter

This block sits at the centre of a switch whose line cards share one data bus. Each card raises a request line while it holds a frame. The arbiter hands the bus to exactly one card at a time, in rotating order. It keeps that card on the bus until the last beat of its frame has been accepted by the receiving side. While the frame is on the bus, every port and the forwarding logic see the same beats. With them comes a header sideband that names the ingress card and carries the destination lookup result captured when the grant was issued.

When the frame ends, the arbiter issues a one-cycle decision to every port. Ports whose bit is set in the transmit vector keep the frame. All the others get a flush pulse and drop their copy. A frame with a lookup miss, or one marked broadcast, goes to every port except the one it came from.

Top module: `shbus_rr_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `grant_o`, `bus_valid_o`, `bus_last_o`, `bus_data_o`, `bus_hdr_o`, `card_ready_o`, `tx_o` and `flush_o` are all zero, and the rotation pointer starts at card 0.
- R2: At most one bit of `grant_o` is set. When the bus is idle and at least one request is present at a clock edge, the grant for the chosen card is visible from the next cycle on.
- R3: The choice scans the cards in increasing index order, wrapping around. The scan starts at the card after the one whose frame finished last, so a card that requests without pause cannot starve the others.
- R4: A grant stays on one card until a beat with `card_valid_i`, `card_last_i` of that card and `bus_ready_i` all high has been accepted. Requests seen during a frame have no effect on `grant_o`.
- R5: `bus_valid_o`, `bus_data_o` and `bus_last_o` follow the granted card's valid, data and last inputs, and all three are zero with no grant. `card_ready_o` equals `bus_ready_i` on the granted card's bit and is zero elsewhere.
- R6: While a card is granted, `bus_hdr_o` holds three fields. Bits [N-1:0] hold the egress mask. Bit N is a known-destination flag, equal to the card's lookup hit AND NOT its broadcast flag. The bits above hold the ingress card number. All three fields are captured at the grant and held for the whole frame. With no grant, `bus_hdr_o` is zero.
- R7: For a known destination, the egress mask is the card's `lk_mask_i` slice, and the transmit vector is that mask with the ingress bit cleared.
- R8: For a lookup miss or a broadcast frame, the egress mask is all ones, and the transmit vector sets every port except the ingress card.
- R9: `tx_o` and `flush_o` are both driven in the cycle after the last beat is accepted. In that cycle `flush_o` is the bitwise complement of `tx_o`. In every other cycle both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NPORT | Per-card bus request |
| card_valid_i | input | NPORT | Per-card beat valid |
| card_last_i | input | NPORT | Per-card last-beat marker |
| card_data_i | input | NPORT*DATA_W | Per-card beat data, card k at [k*DATA_W +: DATA_W] |
| lk_hit_i | input | NPORT | Per-card destination lookup hit |
| lk_bcast_i | input | NPORT | Per-card broadcast marker |
| lk_mask_i | input | NPORT*NPORT | Per-card lookup egress mask, card k at [k*NPORT +: NPORT] |
| bus_ready_i | input | 1 | All receivers accept the current beat |
| grant_o | output | NPORT | One-hot bus grant |
| card_ready_o | output | NPORT | Beat accepted, for the granted card |
| bus_valid_o | output | 1 | Shared bus beat valid |
| bus_last_o | output | 1 | Shared bus last beat |
| bus_data_o | output | DATA_W | Shared bus data |
| bus_hdr_o | output | PORT_W+1+NPORT | Forwarding header sideband |
| tx_o | output | NPORT | Per-port keep-and-transmit pulse |
| flush_o | output | NPORT | Per-port discard pulse |

## Verification
The busiest cycle is the one right after a frame ends. In that cycle the old frame's transmit and flush pulse goes out, and the arbiter picks the next card and captures a new header from its lookup inputs. The bench provokes this with every card requesting without pause and sending single-beat frames with the bus always ready. The new grant then follows each decision with no idle gap. In that cycle the bench's behavioural model checks two things: the decision is built from the finished frame's header, not the one just captured, and the rotation has moved past the card that just finished.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_XFER = 1'b1
   } arb_state_e;

   function automatic int wrap_next(input int cur, input int n);
      return (cur + 1 >= n) ? 0 : cur + 1;
   endfunction
endpackage

// File: rtl/shbus_rr_pick.sv
module shbus_rr_pick #(
   parameter int NPORT  = 4,
   parameter int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic [NPORT-1:0]  req,
   input  logic [PORT_W-1:0] start,
   output logic              any,
   output logic [PORT_W-1:0] idx
);
   int cand;

   always_comb begin
      any  = 1'b0;
      idx  = '0;
      cand = 0;
      for (int k = 0; k < NPORT; k++) begin
         cand = int'(start) + k;
         if (cand >= NPORT) cand = cand - NPORT;
         if (!any && req[cand]) begin
            any = 1'b1;
            idx = PORT_W'(cand);
         end
      end
   end
endmodule

// File: rtl/shbus_bus_mux.sv
module shbus_bus_mux #(
   parameter int NPORT  = 4,
   parameter int DATA_W = 8
) (
   input  logic [NPORT-1:0]        grant,
   input  logic [NPORT-1:0]        valid,
   input  logic [NPORT-1:0]        last,
   input  logic [NPORT*DATA_W-1:0] data,
   output logic                    bus_valid,
   output logic                    bus_last,
   output logic [DATA_W-1:0]       bus_data
);
   logic [DATA_W-1:0] term [NPORT];

   for (genvar g = 0; g < NPORT; g++) begin : g_term
      assign term[g] = grant[g] ? data[g*DATA_W +: DATA_W] : '0;
   end

   always_comb begin
      bus_data = '0;
      for (int k = 0; k < NPORT; k++) bus_data = bus_data | term[k];
   end

   assign bus_valid = |(grant & valid);
   assign bus_last  = |(grant & valid & last);
endmodule

// File: rtl/shbus_egress_decide.sv
module shbus_egress_decide #(
   parameter int NPORT  = 4,
   parameter int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [PORT_W-1:0] ing,
   input  logic [NPORT-1:0]  mask,
   output logic [NPORT-1:0]  tx_o,
   output logic [NPORT-1:0]  flush_o
);
   logic [NPORT-1:0] ing_bit;
   logic [NPORT-1:0] keep;

   for (genvar g = 0; g < NPORT; g++) begin : g_ing
      assign ing_bit[g] = (ing == PORT_W'(g));
   end
   assign keep = mask & ~ing_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_o    <= '0;
         flush_o <= '0;
      end else if (done) begin
         tx_o    <= keep;
         flush_o <= ~keep;
      end else begin
         tx_o    <= '0;
         flush_o <= '0;
      end
   end

   a_r9_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ((tx_o | flush_o) == '1) && ((tx_o & flush_o) == '0));
   a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (tx_o == '0) && (flush_o == '0));
   a_r7_no_reflect: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !tx_o[$past(ing)]);
endmodule

// File: rtl/shbus_rr_arbiter.sv
module shbus_rr_arbiter #(
   parameter int NPORT  = 4,
   parameter int DATA_W = 8,
   parameter int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1,
   parameter int HDR_W  = PORT_W + 1 + NPORT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        req_i,
   input  logic [NPORT-1:0]        card_valid_i,
   input  logic [NPORT-1:0]        card_last_i,
   input  logic [NPORT*DATA_W-1:0] card_data_i,
   input  logic [NPORT-1:0]        lk_hit_i,
   input  logic [NPORT-1:0]        lk_bcast_i,
   input  logic [NPORT*NPORT-1:0]  lk_mask_i,
   input  logic                    bus_ready_i,
   output logic [NPORT-1:0]        grant_o,
   output logic [NPORT-1:0]        card_ready_o,
   output logic                    bus_valid_o,
   output logic                    bus_last_o,
   output logic [DATA_W-1:0]       bus_data_o,
   output logic [HDR_W-1:0]        bus_hdr_o,
   output logic [NPORT-1:0]        tx_o,
   output logic [NPORT-1:0]        flush_o
);
   import shbus_pkg::*;

   if (NPORT < 2)               begin : g_chk_n  $error("NPORT must be at least 2"); end
   if (DATA_W < 1)              begin : g_chk_w  $error("DATA_W must be positive"); end
   if (PORT_W < $clog2(NPORT))  begin : g_chk_p  $error("PORT_W too narrow"); end
   if (HDR_W != PORT_W+1+NPORT) begin : g_chk_h  $error("HDR_W must match fields"); end

   arb_state_e        st_q;
   logic [PORT_W-1:0] own_q, ptr_q;
   logic              known_q;
   logic [NPORT-1:0]  mask_q;
   logic              pick_any;
   logic [PORT_W-1:0] pick_idx;
   logic              busy, done;
   logic              cap_known;
   logic [NPORT-1:0]  cap_mask;

   shbus_rr_pick #(.NPORT(NPORT), .PORT_W(PORT_W)) u_pick (
      .req   (req_i),
      .start (ptr_q),
      .any   (pick_any),
      .idx   (pick_idx)
   );

   assign busy = (st_q == ARB_XFER);

   for (genvar g = 0; g < NPORT; g++) begin : g_grant
      assign grant_o[g] = busy && (own_q == PORT_W'(g));
   end

   shbus_bus_mux #(.NPORT(NPORT), .DATA_W(DATA_W)) u_mux (
      .grant     (grant_o),
      .valid     (card_valid_i),
      .last      (card_last_i),
      .data      (card_data_i),
      .bus_valid (bus_valid_o),
      .bus_last  (bus_last_o),
      .bus_data  (bus_data_o)
   );

   assign card_ready_o = grant_o & {NPORT{bus_ready_i}};
   assign done         = busy && bus_last_o && bus_ready_i;

   assign cap_known = lk_hit_i[pick_idx] && !lk_bcast_i[pick_idx];
   assign cap_mask  = cap_known ? lk_mask_i[pick_idx*NPORT +: NPORT] : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ARB_IDLE;
         own_q   <= '0;
         ptr_q   <= '0;
         known_q <= 1'b0;
         mask_q  <= '0;
      end else if (!busy) begin
         if (pick_any) begin
            st_q    <= ARB_XFER;
            own_q   <= pick_idx;
            known_q <= cap_known;
            mask_q  <= cap_mask;
         end
      end else if (done) begin
         st_q  <= ARB_IDLE;
         ptr_q <= PORT_W'(wrap_next(int'(own_q), NPORT));
      end
   end

   assign bus_hdr_o = busy ? {own_q, known_q, mask_q} : '0;

   shbus_egress_decide #(.NPORT(NPORT), .PORT_W(PORT_W)) u_decide (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done),
      .ing     (own_q),
      .mask    (mask_q),
      .tx_o    (tx_o),
      .flush_o (flush_o)
   );

   a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   a_r4_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(grant_o) && $stable(bus_hdr_o));
   a_r5_ready_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (card_ready_o & ~grant_o) == '0);
   a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (int'(ptr_q) == wrap_next(int'($past(own_q)), NPORT)) && !busy);
   a_r2_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (req_i != '0)) |=> (grant_o != '0));
endmodule

// File: tb/tb_shbus_rr_arbiter.sv
module tb_shbus_rr_arbiter;
   localparam int N  = 4;
   localparam int DW = 8;
   localparam int PW = 2;
   localparam int HW = PW + 1 + N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    req, cval, clast, hit, bc;
   logic [N*DW-1:0] cdata;
   logic [N*N-1:0]  lmask;
   logic            bready;
   logic [N-1:0]    grant, cready, tx, fl;
   logic            bvalid, blast;
   logic [DW-1:0]   bdata;
   logic [HW-1:0]   bhdr;

   int checks = 0;
   int errors = 0;
   bit done_run = 0;

   always #10 clk = ~clk;

   shbus_rr_arbiter dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .card_valid_i(cval),
      .card_last_i(clast), .card_data_i(cdata), .lk_hit_i(hit),
      .lk_bcast_i(bc), .lk_mask_i(lmask), .bus_ready_i(bready),
      .grant_o(grant), .card_ready_o(cready), .bus_valid_o(bvalid),
      .bus_last_o(blast), .bus_data_o(bdata), .bus_hdr_o(bhdr),
      .tx_o(tx), .flush_o(fl)
   );

   // behavioural reference
   bit            m_busy;
   int            m_own, m_ptr;
   bit            m_known;
   logic [N-1:0]  m_mask, m_tx, m_fl;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_own = 0; m_ptr = 0; m_known = 0;
         m_mask = '0; m_tx = '0; m_fl = '0;
      end else begin
         m_tx = '0; m_fl = '0;
         if (m_busy) begin
            if (cval[m_own] && clast[m_own] && bready) begin
               logic [N-1:0] keep;
               keep = m_mask;
               keep[m_own] = 1'b0;
               m_tx = keep; m_fl = ~keep;
               m_busy = 0;
               m_ptr = (m_own + 1) % N;
            end
         end else begin
            for (int k = 0; k < N; k++) begin
               int c;
               c = (m_ptr + k) % N;
               if (!m_busy && req[c]) begin
                  m_busy = 1; m_own = c;
                  m_known = hit[c] && !bc[c];
                  m_mask = m_known ? lmask[c*N +: N] : '1;
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #5;
      if (rst_n && !done_run) begin
         logic [N-1:0]  eg;
         logic [HW-1:0] eh;
         eg = m_busy ? (N'(1) << m_own) : '0;
         eh = m_busy ? {PW'(m_own), m_known, m_mask} : '0;
         chk("R2/R3/R4 grant", 64'(grant), 64'(eg));
         chk("R5 bus_valid", 64'(bvalid), 64'(m_busy && cval[m_own]));
         chk("R5 bus_last",  64'(blast),  64'(m_busy && cval[m_own] && clast[m_own]));
         chk("R5 bus_data",  64'(bdata),  m_busy ? 64'(cdata[m_own*DW +: DW]) : 64'd0);
         chk("R5 card_ready", 64'(cready), 64'(eg & {N{bready}}));
         chk("R6/R7/R8 header", 64'(bhdr), 64'(eh));
         chk("R9/R7/R8 tx", 64'(tx), 64'(m_tx));
         chk("R9 flush", 64'(fl), 64'(m_fl));
      end
   end

   task automatic drive(input int pr, input int pv, input int pl, input int pb,
                        input int ph, input int pc);
      for (int k = 0; k < N; k++) begin
         req[k]   = ($urandom % 100) < pr;
         cval[k]  = ($urandom % 100) < pv;
         clast[k] = ($urandom % 100) < pl;
         hit[k]   = ($urandom % 100) < ph;
         bc[k]    = ($urandom % 100) < pc;
         cdata[k*DW +: DW] = DW'($urandom);
         lmask[k*N +: N]   = N'($urandom);
      end
      bready = ($urandom % 100) < pb;
   endtask

   initial begin
      void'($urandom(7));
      req = '0; cval = '0; clast = '0; hit = '0; bc = '0;
      cdata = '0; lmask = '0; bready = 1'b0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1 grant", 64'(grant), 0);
      chk("R1 bus", 64'({bvalid, blast, bdata}), 0);
      chk("R1 hdr", 64'(bhdr), 0);
      chk("R1 tx/flush", 64'({tx, fl}), 0);
      rst_n = 1'b1;
      // R3/R9 back-to-back: all request, single-beat frames, bus always ready
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         req = '1; cval = '1; clast = '1; bready = 1'b1;
         hit = (i % 3 == 0) ? '1 : '0;
         bc = (i % 5 == 0) ? 4'b0010 : '0;
         lmask = {N*N{1'b1}} ^ (N*N)'(i * 37);
         cdata = (N*DW)'(i * 1234567);
      end
      // R4/R5 long frames, ready mostly low, changing requests
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk);
         drive(60, 70, 15, 40, 70, 10);
      end
      // R7/R8 mixed lookups, mostly hits
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk);
         drive(50, 90, 40, 90, 80, 25);
      end
      // R2 sparse single requests
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         drive(10, 80, 50, 80, 30, 30);
      end
      @(negedge clk);
      done_run = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule